// File: doc/BRIEF.md
# Stereo 64:1 Decimation Filter Chain

This block sits between a stereo oversampling front end and the audio-rate sample path. It takes narrow two's-complement samples at 64 times the audio rate and returns 24-bit samples at the audio rate. The left and right channels share one datapath in time. Each input sample carries a channel tag, the block keeps separate state for each channel, and each result leaves with the tag of the channel it came from.

The rate drops in two stages. A fourth-order sinc (cascaded integrator-comb) stage divides the rate by 8. Three half-band FIR stages then each divide by 2. Every half-band stage does its work only on the samples it keeps. The last stage's result is saturated and left-aligned into a 24-bit word.

Top module: `decim_chain`

## Requirements
- R1: Reset clears every integrator, comb delay, filter delay line and phase counter, and holds `out_valid` low. After reset, neither channel produces a result until that channel has accepted 64 samples.
- R2: Each channel produces exactly one result per 64 of its own accepted samples. Counting starts at reset.
- R3: The sinc stage keeps four cascaded running sums per channel. They update on every accepted sample of that channel and wrap modulo 2^16. On every 8th sample of a channel, the newest fourth sum passes through four first-difference stages, each with a delay of one decimated sample. The DC gain is 4096.
- R4: Each half-band stage computes (-x[n] + 9x[n-2] + 16x[n-3] + 9x[n-4] - x[n-6]). Here x[n] is the newest of that channel's last seven inputs to the stage. The stage adds 16, shifts arithmetically right by 5 (rounding half up), and produces a result on every second input of that channel. The first input after reset produces no result.
- R5: Samples of one channel never change the results of the other channel.
- R6: The last half-band result is clamped to [-32768, 32767] and shifted left by 8 into `out_data`. The low 8 bits of `out_data` are always zero.
- R7: A constant input x on a channel settles to an output of x * 2^20 on that channel.
- R8: `out_valid` rises 4 clock edges after the edge that accepts the sample completing a 64-sample group.
- R9: Channel tag encoding is 0 for left and 1 for right, on both `in_ch` and `out_ch`. `out_ch` equals the tag of the samples that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input sample is present this cycle |
| in_ch | input | 1 | Channel tag of the input sample (0 left, 1 right) |
| in_data | input | 4 | Oversampled two's-complement sample |
| out_valid | output | 1 | An audio-rate result is present this cycle |
| out_ch | output | 1 | Channel tag of the result |
| out_data | output | 24 | Saturated, left-aligned two's-complement result |

## Verification
A phase counter that slips moves a group boundary. The next result then arrives on the wrong cycle or with the wrong tag, so the error is visible at the very next output. A corrupted running sum or delay-line word shows as wrong data on the following result of that channel. It then decays only after the comb stages and the last half-band window have flushed, which takes about seven audio-rate results. A channel-index fault leaks one channel's data into the other, which shows at once on a channel held at zero.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int NCH = 2;
  localparam int HB_TAPS = 7;
  localparam int HB_SHIFT = 5;
  localparam int HB_GROW = 6;
  localparam int HB_COEF [HB_TAPS] = '{-1, 0, 9, 16, 9, 0, -1};
endpackage

// File: rtl/decim_cic.sv
module decim_cic
  import decim_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int ORDER = 4,
  parameter int RATIO = 8,
  localparam int W    = IN_W + ORDER * $clog2(RATIO),
  localparam int CW   = $clog2(RATIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_ch,
  input  logic signed [IN_W-1:0] in_data,
  output logic                out_valid,
  output logic                out_ch,
  output logic signed [W-1:0] out_data
);

  logic signed [W-1:0] integ [NCH][ORDER];
  logic signed [W-1:0] dly   [NCH][ORDER];
  logic [CW-1:0]       phase [NCH];

  logic signed [W-1:0] integ_nxt [ORDER];
  logic signed [W-1:0] comb_val  [ORDER+1];
  logic                decim_fire;

  assign decim_fire = in_valid && (phase[in_ch] == CW'(RATIO - 1));

  always_comb begin
    integ_nxt[0] = integ[in_ch][0] + W'(in_data);
    for (int k = 1; k < ORDER; k++) integ_nxt[k] = integ[in_ch][k] + integ_nxt[k-1];
    comb_val[0] = integ_nxt[ORDER-1];
    for (int k = 0; k < ORDER; k++) comb_val[k+1] = comb_val[k] - dly[in_ch][k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        phase[c] <= '0;
        for (int k = 0; k < ORDER; k++) begin
          integ[c][k] <= '0;
          dly[c][k]   <= '0;
        end
      end
      out_valid <= 1'b0;
      out_ch    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= decim_fire;
      if (in_valid) begin
        phase[in_ch] <= phase[in_ch] + 1'b1;
        for (int k = 0; k < ORDER; k++) integ[in_ch][k] <= integ_nxt[k];
      end
      if (decim_fire) begin
        for (int k = 0; k < ORDER; k++) dly[in_ch][k] <= comb_val[k];
        out_ch   <= in_ch;
        out_data <= comb_val[ORDER];
      end
    end
  end

  AST_CIC_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R3

endmodule

// File: rtl/decim_halfband.sv
module decim_halfband
  import decim_pkg::*;
#(
  parameter int W = 17,
  localparam int SW = W + HB_GROW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_ch,
  input  logic signed [W-1:0] in_data,
  output logic                out_valid,
  output logic                out_ch,
  output logic signed [W-1:0] out_data
);

  logic signed [W-1:0] line  [NCH][HB_TAPS-1];
  logic                phase [NCH];
  logic signed [W-1:0] win   [HB_TAPS];
  logic signed [SW-1:0] mac_out;
  logic signed [SW-1:0] rounded;
  logic                hb_fire;

  function automatic logic signed [SW-1:0] hb_mac(input logic signed [W-1:0] w [HB_TAPS]);
    logic signed [SW-1:0] acc;
    acc = '0;
    for (int k = 0; k < HB_TAPS; k++)
      if (HB_COEF[k] != 0) acc = acc + SW'(w[k] * HB_COEF[k]);
    return acc;
  endfunction

  function automatic logic signed [SW-1:0] round_shift(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] half;
    half = SW'(1 <<< (HB_SHIFT - 1));
    return (v + half) >>> HB_SHIFT;
  endfunction

  always_comb begin
    win[0] = in_data;
    for (int k = 1; k < HB_TAPS; k++) win[k] = line[in_ch][k-1];
  end

  assign hb_fire = in_valid && phase[in_ch];
  assign mac_out = hb_mac(win);
  assign rounded = round_shift(mac_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        phase[c] <= 1'b0;
        for (int k = 0; k < HB_TAPS - 1; k++) line[c][k] <= '0;
      end
      out_valid <= 1'b0;
      out_ch    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= hb_fire;
      if (in_valid) begin
        phase[in_ch] <= ~phase[in_ch];
        for (int k = 0; k < HB_TAPS - 1; k++) line[in_ch][k] <= win[k];
      end
      if (hb_fire) begin
        out_ch   <= in_ch;
        out_data <= rounded[W-1:0];
      end
    end
  end

  AST_HB_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && (out_ch == $past(in_ch)))); // R9

endmodule

// File: rtl/decim_chain.sv
module decim_chain
  import decim_pkg::*;
#(
  parameter int IN_W      = 4,
  parameter int OUT_W     = 24,
  parameter int CIC_ORDER = 4,
  parameter int CIC_RATIO = 8,
  parameter int NUM_HB    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_ch,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic                    out_ch,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int CIC_W = IN_W + CIC_ORDER * $clog2(CIC_RATIO);
  localparam int HB_W  = CIC_W + 1;
  localparam int ALIGN = OUT_W - CIC_W;
  localparam int TOTAL = CIC_RATIO * (2 ** NUM_HB);
  localparam int SLACK = NUM_HB + 1;
  localparam logic signed [HB_W-1:0] TOP_V = HB_W'((1 <<< (CIC_W - 1)) - 1);
  localparam logic signed [HB_W-1:0] BOT_V = -TOP_V - HB_W'(1);
  localparam logic signed [OUT_W-1:0] OUT_MAX = OUT_W'(TOP_V) <<< ALIGN;
  localparam logic signed [OUT_W-1:0] OUT_MIN = OUT_W'(BOT_V) <<< ALIGN;

  logic                    cic_valid;
  logic                    cic_ch;
  logic signed [CIC_W-1:0] cic_data;

  logic                   hv [NUM_HB+1];
  logic                   hc [NUM_HB+1];
  logic signed [HB_W-1:0] hd [NUM_HB+1];

  function automatic logic signed [OUT_W-1:0] sat_align(input logic signed [HB_W-1:0] v);
    logic signed [HB_W-1:0] c;
    if (v > TOP_V)      c = TOP_V;
    else if (v < BOT_V) c = BOT_V;
    else                c = v;
    return OUT_W'(c) <<< ALIGN;
  endfunction

  decim_cic #(.IN_W(IN_W), .ORDER(CIC_ORDER), .RATIO(CIC_RATIO)) u_cic (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .out_valid(cic_valid), .out_ch(cic_ch), .out_data(cic_data)
  );

  assign hv[0] = cic_valid;
  assign hc[0] = cic_ch;
  assign hd[0] = HB_W'(cic_data);

  for (genvar s = 0; s < NUM_HB; s++) begin : g_hb
    decim_halfband #(.W(HB_W)) u_hb (
      .clk(clk), .rst_n(rst_n),
      .in_valid(hv[s]), .in_ch(hc[s]), .in_data(hd[s]),
      .out_valid(hv[s+1]), .out_ch(hc[s+1]), .out_data(hd[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ch    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= hv[NUM_HB];
      if (hv[NUM_HB]) begin
        out_ch   <= hc[NUM_HB];
        out_data <= sat_align(hd[NUM_HB]);
      end
    end
  end

  // Checker state: samples accepted and results issued per channel
  logic [15:0] in_cnt  [NCH];
  logic [15:0] out_cnt [NCH];
  logic [15:0] rate_gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        in_cnt[c]  <= '0;
        out_cnt[c] <= '0;
      end
    end else begin
      if (in_valid)  in_cnt[in_ch]   <= in_cnt[in_ch] + 16'd1;
      if (out_valid) out_cnt[out_ch] <= out_cnt[out_ch] + 16'd1;
    end
  end

  assign rate_gap = in_cnt[out_ch] - ((out_cnt[out_ch] + 16'd1) * 16'(TOTAL));

  AST_RATE_PER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rate_gap <= 16'(SLACK))); // R2

  AST_SAT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (hv[NUM_HB] && (hd[NUM_HB] > TOP_V)) |=> (out_data == OUT_MAX)); // R6

  AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (hv[NUM_HB] && (hd[NUM_HB] < BOT_V)) |=> (out_data == OUT_MIN)); // R6

endmodule

// File: tb/decim_chain_bench.sv
module decim_chain_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NSEG = 6;
  // columns: left A/B, right A/B (alternate per frame), settled left/right result
  localparam int T_LA [NSEG] = '{0, 7, -8, 7, 7, -5};
  localparam int T_LB [NSEG] = '{0, 7, -8, -7, -8, -5};
  localparam int T_RA [NSEG] = '{0, -8, 7, 3, -1, 1};
  localparam int T_RB [NSEG] = '{0, -8, 7, 3, -1, -2};
  localparam int T_EL [NSEG] = '{0, 7340032, -8388608, 0, -524288, -5242880};
  localparam int T_ER [NSEG] = '{0, -8388608, 7340032, 3145728, -1048576, -524288};
  localparam int SEG_FRAMES = 640;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ch = 1'b0;
  logic signed [3:0] in_data = '0;
  logic out_valid;
  logic out_ch;
  logic signed [23:0] out_data;

  decim_chain u_decim_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  longint m_int [2][4];
  longint m_cmb [2][4];
  int     m_cph [2];
  longint m_line [3][2][7];
  int     m_hph [3][2];
  int     sat_seen = 0;
  int     exp_d [$];
  int     exp_c [$];
  int     exp_t [$];

  function automatic longint wrap16(input longint v);
    longint r;
    r = v % 65536;
    if (r < 0) r += 65536;
    if (r >= 32768) r -= 65536;
    return r;
  endfunction

  function automatic longint floor_div32(input longint n);
    longint q;
    q = n / 32;
    if ((n % 32 != 0) && (n < 0)) q = q - 1;
    return q;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_cph[c] = 0;
      for (int k = 0; k < 4; k++) begin m_int[c][k] = 0; m_cmb[c][k] = 0; end
      for (int s = 0; s < 3; s++) begin
        m_hph[s][c] = 0;
        for (int k = 0; k < 7; k++) m_line[s][c][k] = 0;
      end
    end
    exp_d.delete(); exp_c.delete(); exp_t.delete();
  endtask

  task automatic model_step(input int ch, input int x, input int when);
    longint v, t, acc;
    bit go;
    m_int[ch][0] = wrap16(m_int[ch][0] + x);
    for (int k = 1; k < 4; k++) m_int[ch][k] = wrap16(m_int[ch][k] + m_int[ch][k-1]);
    m_cph[ch]++;
    if (m_cph[ch] < 8) return;
    m_cph[ch] = 0;
    v = m_int[ch][3];
    for (int k = 0; k < 4; k++) begin
      t = wrap16(v - m_cmb[ch][k]);
      m_cmb[ch][k] = v;
      v = t;
    end
    go = 1'b1;
    for (int s = 0; s < 3; s++) begin
      if (go) begin
        for (int k = 6; k > 0; k--) m_line[s][ch][k] = m_line[s][ch][k-1];
        m_line[s][ch][0] = v;
        m_hph[s][ch]++;
        if (m_hph[s][ch] == 2) begin
          m_hph[s][ch] = 0;
          acc = 16 * m_line[s][ch][3] + 9 * (m_line[s][ch][2] + m_line[s][ch][4])
                - m_line[s][ch][0] - m_line[s][ch][6];
          v = floor_div32(acc + 16);
        end else go = 1'b0;
      end
    end
    if (!go) return;
    if (v > 32767)  begin v = 32767;  sat_seen++; end
    if (v < -32768) begin v = -32768; sat_seen++; end
    exp_d.push_back(int'(v * 256));
    exp_c.push_back(ch);
    exp_t.push_back(when + 4);
  endtask

  // ---------------- monitor ----------------
  int cnt_l = 0, cnt_r = 0, last_l = 0, last_r = 0, r_nonzero = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_ch) begin cnt_r++; last_r = out_data; if (out_data != 0) r_nonzero++; end
      else begin cnt_l++; last_l = out_data; end
      check(out_data[7:0] == 8'd0, "R6 low bits zero", int'(out_data[7:0]), 0);
      if (exp_d.size() == 0) begin
        check(1'b0, "R2 unexpected result", int'(out_ch), -1);
      end else begin
        check(out_data == exp_d[0], "R3/R4 data vs model", out_data, exp_d[0]);
        check(out_ch == exp_c[0][0], "R9 channel tag", int'(out_ch), exp_c[0]);
        check(cyc == exp_t[0], "R8 latency cycle", cyc, exp_t[0]);
        void'(exp_d.pop_front()); void'(exp_c.pop_front()); void'(exp_t.pop_front());
      end
    end
  end

  // ---------------- drivers ----------------
  task automatic put(input int ch, input int x);
    @(negedge clk);
    in_valid = 1'b1;
    in_ch = ch[0];
    in_data = x[3:0];
    @(posedge clk);
    #1;
    model_step(ch, x, cyc);
  endtask

  task automatic frame(input int l, input int r);
    put(0, l);
    put(1, r);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    model_clear();
    rst_n = 1'b1;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int bl, br;
    model_clear();
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

    // R1: 63 frames give nothing, the 64th gives one result per channel (R2)
    bl = cnt_l; br = cnt_r;
    for (int f = 0; f < 63; f++) frame(5, -3);
    idle(8);
    check(cnt_l + cnt_r == bl + br, "R1 no result before 64 samples", cnt_l + cnt_r - bl - br, 0);
    frame(5, -3);
    idle(8);
    check(cnt_l - bl == 1, "R2 one left result per 64", cnt_l - bl, 1);
    check(cnt_r - br == 1, "R2 one right result per 64", cnt_r - br, 1);

    // R1: reset mid-stream, then zeros must give exactly zero
    for (int f = 0; f < 20; f++) frame(7, 7);
    do_reset();
    bl = cnt_l; br = cnt_r;
    for (int f = 0; f < 64; f++) frame(0, 0);
    idle(8);
    check(cnt_l - bl == 1, "R1 left group restarts after reset", cnt_l - bl, 1);
    check(last_l == 0, "R1 left state cleared", last_l, 0);
    check(last_r == 0, "R1 right state cleared", last_r, 0);

    // table of segments: R7 settled values, R2 counts, model compare per result
    do_reset();
    bl = cnt_l; br = cnt_r;
    for (int s = 0; s < NSEG; s++) begin
      for (int f = 0; f < SEG_FRAMES; f++)
        frame((f % 2 == 0) ? T_LA[s] : T_LB[s], (f % 2 == 0) ? T_RA[s] : T_RB[s]);
      idle(8);
      check(last_l == T_EL[s], "R7 settled left", last_l, T_EL[s]);
      check(last_r == T_ER[s], "R7 settled right", last_r, T_ER[s]);
    end
    check(cnt_l - bl == NSEG * SEG_FRAMES / 64, "R2 left result count", cnt_l - bl, NSEG * SEG_FRAMES / 64);
    check(cnt_r - br == NSEG * SEG_FRAMES / 64, "R2 right result count", cnt_r - br, NSEG * SEG_FRAMES / 64);
    $display("info: model saturation events %0d (R6)", sat_seen);

    // R5: busy left channel, silent right channel
    do_reset();
    bl = r_nonzero;
    for (int f = 0; f < 448; f++) frame((f % 3 == 0) ? -8 : 7, 0);
    idle(8);
    check(r_nonzero == bl, "R5 right untouched by left", r_nonzero - bl, 0);
    check(last_l != 0, "R5 left active", last_l, 1);

    check(exp_d.size() == 0, "R2 all expected results seen", exp_d.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule